// File: doc/BRIEF.md
# Barrel Shifter with Carry Selection

This unit is the shift and rotate slice of a small processor datapath. In one cycle it moves a 32-bit operand left or right by any distance from 0 to 31. It does this as a plain logical shift, a plain rotate, or a rotate that passes through the carry flag. The shifted word appears combinationally on the result port, together with a write enable for the destination register. The carry and zero flags are held in registers inside the unit and change on the clock edge of a qualified operation.

By default the carry flag takes the last bit that a multi-bit shift pushed off the end of the word. This lets software test any single bit by shifting it out, and makes rotate-through-carry a lossless 33-bit rotation. A legacy input selects the older rule instead: the carry is the operand's end bit on the exit side, whatever the distance. A keep-destination control suppresses the result write while the flags still update, which turns any shift into a non-destructive bit test.

The operation strobe `in_valid` has no back-pressure. The unit takes a new operation on every cycle that the strobe is high, and it has no ready output. A cycle with the strobe low leaves the flags untouched.

Top module: `bshift_cflag`

## Requirements
- R1: Op code 000 is a logical left shift and 001 a logical right shift, each by `in_amt` (0..31). Vacated bit positions are filled with zeros.
- R2: Op code 010 rotates left and 011 rotates right by `in_amt`. Bits leaving one end re-enter at the other, so the set of bit values is preserved.
- R3: With `legacy_sel` low and `in_amt` = n ≥ 1, the carry produced is original bit n−1 for right-direction ops (odd op codes) and original bit 32−n for left-direction ops (even op codes). So SHR by 23 and SHL by 10 both yield original bit 22.
- R4: With `legacy_sel` low, op code 100 rotates the 33-bit value {`in_carry`, `in_data`} left by n, and op code 101 rotates it right by n. The low 32 bits form the result and bit 32 forms the carry.
- R5: With `legacy_sel` high, the carry produced is original bit 0 for right-direction ops and original bit 31 for left-direction ops. Op codes 100 and 101 then shift, filling the vacated positions with copies of `in_carry`.
- R6: When `in_amt` is 0, the result equals `in_data` and `flag_c` keeps its value, even if `upd_c` is high.
- R7: On a valid legal op, `flag_c` loads the produced carry only when `upd_c` is high. `flag_z` loads (result == 0) only when `upd_z` is high.
- R8: `out_we` is high exactly when `in_valid` is high and `keep_dst` is low. `keep_dst` does not block flag updates.
- R9: Op codes 110 and 111 pass `in_data` to the result unchanged and update neither flag.
- R10: When `in_valid` is low, neither flag changes.
- R11: A high `rst` at a rising edge clears both `flag_c` and `flag_z` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| in_valid | input | 1 | Operation strobe; qualifies flag updates and the result write |
| in_data | input | 32 | Operand to shift or rotate |
| in_amt | input | 5 | Shift or rotate distance |
| in_op | input | 3 | Operation code (see R1, R2, R4, R9) |
| in_carry | input | 1 | Incoming carry used by through-carry ops |
| legacy_sel | input | 1 | High selects the end-bit carry rule |
| upd_c | input | 1 | Allow the carry flag to load |
| upd_z | input | 1 | Allow the zero flag to load |
| keep_dst | input | 1 | Suppress the destination write |
| out_data | output | 32 | Shifted or rotated result (combinational) |
| out_we | output | 1 | Destination write enable |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |

## Verification
Assertions watch several properties on every cycle. A zero distance or an illegal op leaves the word unchanged. Plain rotates keep the count of set bits. Logical shifts clear the entry-side bit. The carry flag holds whenever no qualified load happens, and it follows the end-bit rule in legacy mode and the last-out rule otherwise. The two independent carry paths of through-carry rotation must agree, and the zero flag must match the previous result. The bench's scenarios are needed for exact whole-word values under every op and mode, the specific bit-22 cases, the interplay of keep-destination with flag updates, and reset arriving while the flags are set.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [2:0] {
    OP_SHL = 3'b000,
    OP_SHR = 3'b001,
    OP_ROL = 3'b010,
    OP_ROR = 3'b011,
    OP_RCL = 3'b100,
    OP_RCR = 3'b101
  } shop_e;

  function automatic logic op_legal(input logic [2:0] op);
    return op <= 3'b101;
  endfunction

  function automatic logic op_is_left(input logic [2:0] op);
    return ~op[0];
  endfunction
endpackage

// File: rtl/bsc_rotator.sv
module bsc_rotator #(
  parameter int W  = 32,
  parameter int CW = 5
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amt,
  input  logic          left,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [CW+1];

  assign stg[0] = din;

  for (genvar s = 0; s < CW; s++) begin : g_stage
    localparam int A = 2 ** s;
    logic [W-1:0] rl, rr;
    assign rl = {stg[s][W-1-A:0], stg[s][W-1:W-A]};
    assign rr = {stg[s][A-1:0], stg[s][W-1:A]};
    assign stg[s+1] = amt[s] ? (left ? rl : rr) : stg[s];
  end

  assign dout = stg[CW];
endmodule

// File: rtl/bsc_carry_pick.sv
module bsc_carry_pick #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amt,
  input  logic          left,
  input  logic          legacy,
  output logic          cout
);
  logic [CW-1:0] idx_r, idx_l;

  // right: last bit out sits at amt-1; left: at W-amt (mod W)
  assign idx_r = amt - 1'b1;
  assign idx_l = ~amt + 1'b1;

  always_comb begin
    if (legacy) cout = left ? din[W-1] : din[0];
    else        cout = left ? din[idx_l] : din[idx_r];
  end
endmodule

// File: rtl/bsc_datapath.sv
module bsc_datapath
  import bsc_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amt,
  input  logic [2:0]    op,
  input  logic          cin,
  input  logic          legacy,
  output logic [W-1:0]  dout,
  output logic          rc_carry
);
  logic         left;
  logic [W-1:0] rot_w, mask;
  logic [W:0]   rot_c;

  assign left = op_is_left(op);

  bsc_rotator #(.W(W), .CW(CW)) u_rot_w (
    .din(din), .amt(amt), .left(left), .dout(rot_w)
  );

  bsc_rotator #(.W(W+1), .CW(CW)) u_rot_c (
    .din({cin, din}), .amt(amt), .left(left), .dout(rot_c)
  );

  assign mask     = left ? ({W{1'b1}} << amt) : ({W{1'b1}} >> amt);
  assign rc_carry = rot_c[W];

  always_comb begin
    case (op)
      OP_SHL, OP_SHR: dout = rot_w & mask;
      OP_ROL, OP_ROR: dout = rot_w;
      OP_RCL, OP_RCR: dout = legacy ? ((rot_w & mask) | (~mask & {W{cin}}))
                                    : rot_c[W-1:0];
      default:        dout = din;
    endcase
  end

  always_comb begin
    if (op == OP_ROL || op == OP_ROR)
      p_rot_ones_r2: assert ($countones(dout) == $countones(din));
    if (op == OP_SHL && amt != '0)
      p_shl_fill_r1: assert (dout[0] == 1'b0);
    if (op == OP_SHR && amt != '0)
      p_shr_fill_r1: assert (dout[W-1] == 1'b0);
  end
endmodule

// File: rtl/bsc_flags.sv
module bsc_flags (
  input  logic clk,
  input  logic rst,
  input  logic c_we,
  input  logic c_nxt,
  input  logic z_we,
  input  logic z_nxt,
  output logic c_q,
  output logic z_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      if (c_we) c_q <= c_nxt;
      if (z_we) z_q <= z_nxt;
    end
  end

  p_reset_clear_r11: assert property (@(posedge clk) rst |=> (!c_q && !z_q));
endmodule

// File: rtl/bshift_cflag.sv
module bshift_cflag
  import bsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         in_data,
  input  logic [$clog2(DATA_W)-1:0] in_amt,
  input  logic [2:0]                in_op,
  input  logic                      in_carry,
  input  logic                      legacy_sel,
  input  logic                      upd_c,
  input  logic                      upd_z,
  input  logic                      keep_dst,
  output logic [DATA_W-1:0]         out_data,
  output logic                      out_we,
  output logic                      flag_c,
  output logic                      flag_z
);
  localparam int CNT_W = $clog2(DATA_W);

  logic legal, pick_c, rc_c, c_load, z_load, res_zero;

  assign legal = op_legal(in_op);

  bsc_datapath #(.W(DATA_W), .CW(CNT_W)) u_dp (
    .din(in_data), .amt(in_amt), .op(in_op), .cin(in_carry),
    .legacy(legacy_sel), .dout(out_data), .rc_carry(rc_c)
  );

  bsc_carry_pick #(.W(DATA_W), .CW(CNT_W)) u_pick (
    .din(in_data), .amt(in_amt), .left(op_is_left(in_op)),
    .legacy(legacy_sel), .cout(pick_c)
  );

  assign c_load   = in_valid && legal && upd_c && (in_amt != '0);
  assign z_load   = in_valid && legal && upd_z;
  assign res_zero = (out_data == '0);
  assign out_we   = in_valid && !keep_dst;

  bsc_flags u_flags (
    .clk(clk), .rst(rst), .c_we(c_load), .c_nxt(pick_c),
    .z_we(z_load), .z_nxt(res_zero), .c_q(flag_c), .z_q(flag_z)
  );

  always_comb begin
    if (keep_dst) p_keep_no_we_r8: assert (!out_we);
  end

  p_amt0_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (in_amt == '0) |-> (out_data == in_data));

  p_illegal_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (in_op > 3'b101) |-> (out_data == in_data));

  p_c_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && upd_c && in_amt != '0 && in_op <= 3'b101) |=> $stable(flag_c));

  p_z_track_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && upd_z && in_op <= 3'b101) |=> (flag_z == ($past(out_data) == '0)));

  p_carry_legacy_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && upd_c && legacy_sel && in_amt != '0 && in_op <= 3'b101) |=>
      (flag_c == $past(in_op[0] ? in_data[0] : in_data[DATA_W-1])));

  p_carry_last_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && upd_c && !legacy_sel && in_amt != '0 && in_op <= 3'b101) |=>
      (flag_c == $past(in_op[0] ? in_data[in_amt - 1'b1]
                                : in_data[DATA_W - int'(in_amt)])));

  p_rc_agree_r4: assert property (@(posedge clk) disable iff (rst)
    (!legacy_sel && in_amt != '0 && (in_op == 3'b100 || in_op == 3'b101)) |->
      (rc_c == pick_c));
endmodule

// File: tb/bshift_cflag_bench.sv
`timescale 1ns/1ps
module bshift_cflag_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [4:0]  in_amt = '0;
  logic [2:0]  in_op = '0;
  logic        in_carry = 1'b0, legacy_sel = 1'b0;
  logic        upd_c = 1'b0, upd_z = 1'b0, keep_dst = 1'b0;
  logic [31:0] out_data;
  logic        out_we, flag_c, flag_z;

  int errors = 0;
  int checks = 0;
  logic mc = 1'b0, mz = 1'b0;

  always #2.5 clk = ~clk;

  bshift_cflag u_bshift_cflag (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_amt(in_amt), .in_op(in_op), .in_carry(in_carry),
    .legacy_sel(legacy_sel), .upd_c(upd_c), .upd_z(upd_z),
    .keep_dst(keep_dst), .out_data(out_data), .out_we(out_we),
    .flag_c(flag_c), .flag_z(flag_z)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bit-by-bit reference model
  function automatic void ref_op(input logic [2:0] op, input logic [31:0] d,
                                 input logic [4:0] n, input logic cin, input logic leg,
                                 output logic [31:0] r, output logic c);
    logic [31:0] x = d;
    logic cc = cin;
    logic t;
    for (int k = 0; k < int'(n); k++) begin
      case (op)
        3'd0: begin cc = x[31]; x = {x[30:0], 1'b0}; end
        3'd1: begin cc = x[0];  x = {1'b0, x[31:1]}; end
        3'd2: begin cc = x[31]; x = {x[30:0], x[31]}; end
        3'd3: begin cc = x[0];  x = {x[0], x[31:1]}; end
        3'd4: if (leg) x = {x[30:0], cin};
              else begin t = x[31]; x = {x[30:0], cc}; cc = t; end
        3'd5: if (leg) x = {cin, x[31:1]};
              else begin t = x[0]; x = {cc, x[31:1]}; cc = t; end
        default: ;
      endcase
    end
    if (leg && op <= 3'd5) cc = op[0] ? d[0] : d[31];
    r = x;
    c = cc;
  endfunction

  task automatic step(input logic v, input logic [2:0] op, input logic [31:0] d,
                      input logic [4:0] n, input logic cin, input logic leg,
                      input logic wc, input logic wz, input logic kd,
                      input string rtag, input string ftag);
    logic [31:0] er;
    logic ec;
    @(negedge clk);
    in_valid = v; in_op = op; in_data = d; in_amt = n; in_carry = cin;
    legacy_sel = leg; upd_c = wc; upd_z = wz; keep_dst = kd;
    #1;
    ref_op(op, d, n, cin, leg, er, ec);
    check(rtag, out_data, er);
    check("R8 out_we", {31'b0, out_we}, {31'b0, v && !kd});
    if (v && op <= 3'd5) begin
      if (wc && n != 5'd0) mc = ec;
      if (wz) mz = (er == 32'd0);
    end
    @(posedge clk);
    #1;
    check({ftag, " flag_c"}, {31'b0, flag_c}, {31'b0, mc});
    check({ftag, " flag_z"}, {31'b0, flag_z}, {31'b0, mz});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    string rt;
    seed_dummy = $urandom(32'd531);
    repeat (2) @(posedge clk);
    #1;
    check("R11 reset flag_c", {31'b0, flag_c}, 32'd0);
    check("R11 reset flag_z", {31'b0, flag_z}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R3 directed: bit 22 via SHR 23 and SHL 10
    step(1, 3'd1, 32'h0040_0000, 5'd23, 0, 0, 1, 1, 1, "R3 shr23", "R3");
    step(1, 3'd0, 32'hFFBF_FFFF, 5'd10, 0, 0, 1, 1, 1, "R3 shl10", "R3");
    step(1, 3'd0, 32'h0040_0000, 5'd10, 0, 0, 1, 1, 1, "R3 shl10 one", "R3");
    // R1 zero fill
    step(1, 3'd0, 32'hFFFF_FFFF, 5'd31, 0, 0, 1, 1, 0, "R1 shl31", "R1");
    step(1, 3'd1, 32'h8000_0001, 5'd31, 0, 0, 1, 1, 0, "R1 shr31", "R1");
    // R2 rotates
    step(1, 3'd2, 32'h8000_0001, 5'd1, 0, 0, 1, 1, 0, "R2 rol1", "R2");
    step(1, 3'd3, 32'h1234_5678, 5'd16, 0, 0, 1, 1, 0, "R2 ror16", "R2");
    // R4 through-carry 33-bit rotation
    step(1, 3'd4, 32'h8000_0000, 5'd1, 1, 0, 1, 1, 0, "R4 rcl1", "R4");
    step(1, 3'd5, 32'h0000_0001, 5'd31, 1, 0, 1, 1, 0, "R4 rcr31", "R4");
    // R5 legacy carry and fill
    step(1, 3'd1, 32'h0000_0001, 5'd23, 0, 1, 1, 1, 0, "R5 shr legacy", "R5");
    step(1, 3'd4, 32'h0000_0000, 5'd4, 1, 1, 1, 1, 0, "R5 rcl legacy fill", "R5");
    step(1, 3'd2, 32'h7FFF_FFFF, 5'd3, 0, 1, 1, 1, 0, "R5 rol legacy", "R5");
    // R6 count zero keeps carry
    step(1, 3'd1, 32'h0000_0001, 5'd1, 0, 0, 1, 0, 0, "R6 setup", "R6");
    step(1, 3'd1, 32'h0000_0000, 5'd0, 0, 0, 1, 1, 0, "R6 amt0", "R6");
    // R7 update gating
    step(1, 3'd1, 32'h0000_0000, 5'd5, 0, 0, 0, 0, 0, "R7 no upd", "R7");
    step(1, 3'd0, 32'h0000_0001, 5'd1, 0, 0, 0, 1, 0, "R7 z only", "R7");
    // R8 keep_dst with flag update
    step(1, 3'd1, 32'h0000_0003, 5'd2, 0, 0, 1, 1, 1, "R8 keep", "R8");
    // R9 illegal ops
    step(1, 3'd6, 32'h0000_0000, 5'd7, 1, 0, 1, 1, 0, "R9 op6", "R9");
    step(1, 3'd7, 32'hDEAD_BEEF, 5'd3, 0, 0, 1, 1, 0, "R9 op7", "R9");
    // R10 valid low
    step(0, 3'd0, 32'h0000_0000, 5'd1, 0, 0, 1, 1, 0, "R10 result", "R10");
    step(0, 3'd1, 32'hFFFF_FFFF, 5'd1, 0, 0, 1, 1, 0, "R10 result b", "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic leg;
      op  = 3'($urandom_range(0, 7));
      leg = 1'($urandom_range(0, 3) == 0);
      if (op > 3'd5)       rt = "R9 rand";
      else if (leg)        rt = "R5 rand";
      else if (op >= 3'd4) rt = "R4 rand";
      else if (op >= 3'd2) rt = "R2 rand";
      else                 rt = "R1 rand";
      step(1'($urandom_range(0, 7) != 0), op, $urandom, 5'($urandom), 1'($urandom),
           leg, 1'($urandom), 1'($urandom), 1'($urandom), rt, "R7 rand");
    end

    // R11 reset while flags set
    step(1, 3'd0, 32'h8000_0000, 5'd1, 0, 0, 1, 1, 0, "R11 setup", "R11");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    mc = 1'b0; mz = 1'b0;
    check("R11 midrun flag_c", {31'b0, flag_c}, 32'd0);
    check("R11 midrun flag_z", {31'b0, flag_z}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule